// File: doc/BRIEF.md
# Cycle-Stealing Block Transfer Engine

This block moves a block of words between one peripheral and system memory without the processor touching the data. Software first programs four things through a small write/read register port: which way the data flows, the identifier of the peripheral, the first memory word address and the number of words. A start command then hands the job to the engine, and the processor goes on with other work.

For every word the engine first waits until the peripheral can take part: it holds a word ready for a write to memory, or it can accept one for a read from memory. Only then does it raise its bus request. It waits for the grant and runs exactly one memory cycle. It then drops the request, so the processor regains the bus after a single stolen cycle. After each word the address steps up by one and the remaining count steps down by one. When the count runs out, an interrupt line is raised. It stays up until software clears it.

Top module: `dma_steal_top`

## Requirements
- R1: After reset the engine is idle, the interrupt, bus request, memory valid and device handshake outputs are low, and every register reads zero.
- R2: The register port decodes `cfg_addr`. At 0 the control word: a write with bit 0 starts, bit 1 sets direction (1 = memory to device) and bit 2 clears the interrupt; a read returns busy in bit 0, interrupt in bit 1 and direction in bit 2. At 1 is the device identifier (low bits), at 2 the current memory address and at 3 the remaining word count. Reads return live values.
- R3: In device-to-memory direction, each word the device hands over is written (`mem_we` = 1) at the current address. After each completed memory cycle the address rises by one and the count falls by one.
- R4: In memory-to-device direction, each word is read (`mem_we` = 0) from the current address and offered on the device output until the device accepts it, in address order.
- R5: The bus request rises only when the device holds a word for memory or was ready to accept one. No memory cycle runs without the grant.
- R6: The bus request is low in the cycle after each memory cycle completes, so each grant covers exactly one word.
- R7: When the last word finishes, the engine goes idle and the interrupt rises. The interrupt stays high until a control write with bit 2 set.
- R8: While busy, start commands and writes to the direction, identifier, address and count are ignored.
- R9: Starting with a count of zero raises the interrupt without any bus request.
- R10: If a clear write and the completion of a block fall in the same cycle, the interrupt is left set.
- R11: The `dev_id` output carries the programmed device identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read data for `cfg_addr` |
| dev_id | output | IDW | Selected peripheral identifier |
| irq | output | 1 | Block-complete interrupt |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| mem_valid | output | 1 | Memory cycle request |
| mem_ready | input | 1 | Memory cycle complete |
| mem_we | output | 1 | 1 = write memory, 0 = read memory |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid with `mem_ready` |
| dev_rx_valid | input | 1 | Device holds a word for memory |
| dev_rx_ready | output | 1 | Engine accepts the device word |
| dev_rx_data | input | DW | Word from the device |
| dev_tx_valid | output | 1 | Engine offers a word to the device |
| dev_tx_ready | input | 1 | Device accepts / can accept a word |
| dev_tx_data | output | DW | Word to the device |

## Verification
Two events can meet in one cycle: the final word's memory completion, which sets the interrupt, and a software clear of that interrupt. The bench's memory model watches for the handshake that empties the expected-write queue. On that same falling edge it drives a clear write onto the register port, so both reach the flops at one rising edge. The outcome is judged a few cycles later: the interrupt must still read high. A normal clear afterwards must then lower it.

// File: rtl/dma_steal_pkg.sv
package dma_steal_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WAIT = 3'd1,
        ST_REQ  = 3'd2,
        ST_XFER = 3'd3,
        ST_PUSH = 3'd4
    } dma_state_e;

    localparam logic [1:0] REG_CTL  = 2'd0;
    localparam logic [1:0] REG_DEV  = 2'd1;
    localparam logic [1:0] REG_ADDR = 2'd2;
    localparam logic [1:0] REG_CNT  = 2'd3;

    localparam int CTL_GO   = 0;
    localparam int CTL_DIR  = 1;
    localparam int CTL_ACK  = 2;

    localparam int STS_BUSY = 0;
    localparam int STS_IRQ  = 1;
    localparam int STS_DIR  = 2;

endpackage

// File: rtl/dma_steal_regs.sv
module dma_steal_regs
    import dma_steal_pkg::*;
#(
    parameter int DW  = 32,
    parameter int AW  = 16,
    parameter int CW  = 16,
    parameter int IDW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [1:0]     cfg_addr,
    input  logic [DW-1:0]  cfg_wdata,
    output logic [DW-1:0]  cfg_rdata,
    input  logic           busy,
    input  logic           done,
    input  logic [AW-1:0]  cur_addr,
    input  logic [CW-1:0]  cur_cnt,
    output logic           start,
    output logic           ld_addr,
    output logic           ld_cnt,
    output logic           dir,
    output logic [IDW-1:0] dev_id,
    output logic           irq
);

    typedef struct packed {
        logic           dir;
        logic [IDW-1:0] dev;
        logic           irq;
    } regs_t;

    regs_t r_q, r_d;
    logic  wr_ctl, clr;
    wire   unused_wdata = ^cfg_wdata;

    always_comb begin
        r_d     = r_q;
        wr_ctl  = cfg_we && (cfg_addr == REG_CTL);
        start   = wr_ctl && cfg_wdata[CTL_GO] && !busy;
        clr     = wr_ctl && cfg_wdata[CTL_ACK];
        ld_addr = cfg_we && (cfg_addr == REG_ADDR) && !busy;
        ld_cnt  = cfg_we && (cfg_addr == REG_CNT) && !busy;
        if (wr_ctl && !busy) begin
            r_d.dir = cfg_wdata[CTL_DIR];
        end
        if (cfg_we && (cfg_addr == REG_DEV) && !busy) begin
            r_d.dev = cfg_wdata[IDW-1:0];
        end
        if (clr) begin
            r_d.irq = 1'b0;
        end
        if (done) begin
            r_d.irq = 1'b1;
        end
        cfg_rdata = '0;
        case (cfg_addr)
            REG_CTL: begin
                cfg_rdata[STS_BUSY] = busy;
                cfg_rdata[STS_IRQ]  = r_q.irq;
                cfg_rdata[STS_DIR]  = r_q.dir;
            end
            REG_DEV:  cfg_rdata[IDW-1:0] = r_q.dev;
            REG_ADDR: cfg_rdata[AW-1:0]  = cur_addr;
            default:  cfg_rdata[CW-1:0]  = cur_cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign dir    = r_q.dir;
    assign dev_id = r_q.dev;
    assign irq    = r_q.irq;

    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(clr));

    // R10
    irq_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && clr) |=> irq);

    // R8
    dir_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_ctl) |=> $stable(dir));

endmodule

// File: rtl/dma_steal_engine.sv
module dma_steal_engine
    import dma_steal_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dir,
    input  logic          start,
    input  logic          ld_addr,
    input  logic          ld_cnt,
    input  logic [DW-1:0] wdata,
    input  logic          bus_gnt,
    input  logic          mem_ready,
    input  logic [DW-1:0] mem_rdata,
    input  logic          dev_rx_valid,
    input  logic [DW-1:0] dev_rx_data,
    input  logic          dev_tx_ready,
    output logic          busy,
    output logic          done,
    output logic          bus_req,
    output logic          mem_valid,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          dev_rx_ready,
    output logic          dev_tx_valid,
    output logic [DW-1:0] dev_tx_data,
    output logic [AW-1:0] cur_addr,
    output logic [CW-1:0] cur_cnt
);

    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    typedef struct packed {
        dma_state_e    st;
        logic [AW-1:0] addr;
        logic [CW-1:0] cnt;
        logic [DW-1:0] hold;
    } eng_t;

    eng_t r_q, r_d;
    wire  unused_wdata = ^wdata;

    always_comb begin
        r_d          = r_q;
        done         = 1'b0;
        bus_req      = 1'b0;
        mem_valid    = 1'b0;
        dev_rx_ready = 1'b0;
        dev_tx_valid = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (ld_addr) r_d.addr = wdata[AW-1:0];
                if (ld_cnt)  r_d.cnt  = wdata[CW-1:0];
                if (start) begin
                    if (r_q.cnt == '0) begin
                        done = 1'b1;
                    end else begin
                        r_d.st = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (!dir) begin
                    dev_rx_ready = 1'b1;
                    if (dev_rx_valid) begin
                        r_d.hold = dev_rx_data;
                        r_d.st   = ST_REQ;
                    end
                end else if (dev_tx_ready) begin
                    r_d.st = ST_REQ;
                end
            end
            ST_REQ: begin
                bus_req = 1'b1;
                if (bus_gnt) r_d.st = ST_XFER;
            end
            ST_XFER: begin
                bus_req   = 1'b1;
                mem_valid = 1'b1;
                if (mem_ready) begin
                    r_d.addr = r_q.addr + 1'b1;
                    r_d.cnt  = r_q.cnt - 1'b1;
                    if (dir) begin
                        r_d.hold = mem_rdata;
                        r_d.st   = ST_PUSH;
                    end else if (r_q.cnt == CNT_ONE) begin
                        done   = 1'b1;
                        r_d.st = ST_IDLE;
                    end else begin
                        r_d.st = ST_WAIT;
                    end
                end
            end
            ST_PUSH: begin
                dev_tx_valid = 1'b1;
                if (dev_tx_ready) begin
                    if (r_q.cnt == '0) begin
                        done   = 1'b1;
                        r_d.st = ST_IDLE;
                    end else begin
                        r_d.st = ST_WAIT;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy        = (r_q.st != ST_IDLE);
    assign mem_we      = !dir;
    assign mem_addr    = r_q.addr;
    assign mem_wdata   = r_q.hold;
    assign dev_tx_data = r_q.hold;
    assign cur_addr    = r_q.addr;
    assign cur_cnt     = r_q.cnt;

    // R5
    grant_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_valid) |-> $past(bus_gnt));

    // R6
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready) |=> !bus_req);

    // R3
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready) |=>
            (r_q.cnt == $past(r_q.cnt) - 1'b1) && (r_q.addr == $past(r_q.addr) + 1'b1));

    // R9
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && r_q.cnt == '0) |=> (!busy && !bus_req));

endmodule

// File: rtl/dma_steal_top.sv
module dma_steal_top
    import dma_steal_pkg::*;
#(
    parameter int DW  = 32,
    parameter int AW  = 16,
    parameter int CW  = 16,
    parameter int IDW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [1:0]     cfg_addr,
    input  logic [DW-1:0]  cfg_wdata,
    output logic [DW-1:0]  cfg_rdata,
    output logic [IDW-1:0] dev_id,
    output logic           irq,
    output logic           bus_req,
    input  logic           bus_gnt,
    output logic           mem_valid,
    input  logic           mem_ready,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           dev_rx_valid,
    output logic           dev_rx_ready,
    input  logic [DW-1:0]  dev_rx_data,
    output logic           dev_tx_valid,
    input  logic           dev_tx_ready,
    output logic [DW-1:0]  dev_tx_data
);

    logic          busy, done, start, ld_addr, ld_cnt, dir;
    logic [AW-1:0] cur_addr;
    logic [CW-1:0] cur_cnt;

    dma_steal_regs #(.DW(DW), .AW(AW), .CW(CW), .IDW(IDW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .busy      (busy),
        .done      (done),
        .cur_addr  (cur_addr),
        .cur_cnt   (cur_cnt),
        .start     (start),
        .ld_addr   (ld_addr),
        .ld_cnt    (ld_cnt),
        .dir       (dir),
        .dev_id    (dev_id),
        .irq       (irq)
    );

    dma_steal_engine #(.DW(DW), .AW(AW), .CW(CW)) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .dir          (dir),
        .start        (start),
        .ld_addr      (ld_addr),
        .ld_cnt       (ld_cnt),
        .wdata        (cfg_wdata),
        .bus_gnt      (bus_gnt),
        .mem_ready    (mem_ready),
        .mem_rdata    (mem_rdata),
        .dev_rx_valid (dev_rx_valid),
        .dev_rx_data  (dev_rx_data),
        .dev_tx_ready (dev_tx_ready),
        .busy         (busy),
        .done         (done),
        .bus_req      (bus_req),
        .mem_valid    (mem_valid),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .dev_rx_ready (dev_rx_ready),
        .dev_tx_valid (dev_tx_valid),
        .dev_tx_data  (dev_tx_data),
        .cur_addr     (cur_addr),
        .cur_cnt      (cur_cnt)
    );

endmodule

// File: tb/test_dma_steal_top.sv
`timescale 1ns/1ps
module test_dma_steal_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [31:0] host_wdata = '0;
    logic        coll_we = 1'b0;
    logic        cfg_we;
    logic [1:0]  cfg_addr;
    logic [31:0] cfg_wdata, cfg_rdata;
    logic [3:0]  dev_id;
    logic        irq, bus_req, mem_valid, mem_we, dev_rx_ready, dev_tx_valid;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata, dev_tx_data;
    logic        bus_gnt = 1'b0, mem_ready = 1'b0, dev_rx_valid = 1'b0, dev_tx_ready = 1'b0;
    logic [31:0] mem_rdata = '0, dev_rx_data = '0;

    always #5 clk = ~clk;

    assign cfg_we    = host_we | coll_we;
    assign cfg_addr  = coll_we ? 2'd0 : host_addr;
    assign cfg_wdata = coll_we ? 32'd4 : host_wdata;

    dma_steal_top i_dma_steal_top (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dev_id(dev_id), .irq(irq),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_rx_valid(dev_rx_valid),
        .dev_rx_ready(dev_rx_ready), .dev_rx_data(dev_rx_data),
        .dev_tx_valid(dev_tx_valid), .dev_tx_ready(dev_tx_ready),
        .dev_tx_data(dev_tx_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // scoreboard state
    typedef struct { logic [15:0] a; logic [31:0] d; } item_t;
    item_t       expq[$];
    logic [31:0] srcq[$];
    logic [31:0] mem [0:255];
    int  gnt_lat = 1, mem_lat = 1;
    int  gcnt = 0, mcnt = 0, pend = 0, cyc = 0;
    bit  tb_dir = 0, sink_on = 0;
    bit  req_prev = 0, tx_rdy_prev = 0, hs_prev = 0;
    bit  coll_arm = 0, coll_fired = 0;

    // driver tasks push expectations
    task automatic plan_in(input int n, input logic [15:0] base, input logic [31:0] seed);
        for (int i = 0; i < n; i++) begin
            item_t it;
            it.a = base + 16'(i);
            it.d = seed ^ (32'h1111_0000 * (i + 1)) ^ i;
            srcq.push_back(it.d);
            expq.push_back(it);
        end
    endtask

    task automatic plan_out(input int n, input logic [15:0] base, input logic [31:0] seed);
        for (int i = 0; i < n; i++) begin
            item_t it;
            it.a = base + 16'(i);
            it.d = seed + 32'h0101_0101 * i;
            mem[it.a[7:0]] = it.d;
            expq.push_back(it);
        end
    endtask

    // bus, memory and device models with monitor
    always @(negedge clk) begin
        bit hs_now;
        hs_now = 0;
        coll_we = 1'b0;
        if (!rst_n) begin
            bus_gnt = 0; mem_ready = 0; dev_rx_valid = 0; dev_tx_ready = 0;
            gcnt = 0; mcnt = 0; pend = 0;
            req_prev = 0; tx_rdy_prev = 0; hs_prev = 0;
        end else begin
            cyc++;
            if (bus_req) begin
                if (gcnt >= gnt_lat) bus_gnt = 1'b1;
                gcnt++;
            end else begin
                bus_gnt = 1'b0;
                gcnt = 0;
            end
            // R6: request gone one cycle after a word
            if (hs_prev) chk(!bus_req, "R6", "bus_req after word", 32'(bus_req), 0);
            // R5: request only when device side is able
            if (bus_req && !req_prev) begin
                if (!tb_dir) chk(pend == 1, "R5", "words held at request", pend, 1);
                else         chk(tx_rdy_prev, "R5", "device ready before request", 32'(tx_rdy_prev), 1);
            end
            if (mem_valid) begin
                if (mcnt == 0) chk(bus_gnt, "R5", "grant during memory cycle", 32'(bus_gnt), 1);
                if (mcnt >= mem_lat) begin
                    mem_ready = 1'b1;
                    mcnt = 0;
                    hs_now = 1;
                    if (mem_we) begin
                        mem[mem_addr[7:0]] = mem_wdata;
                        pend--;
                        if (expq.size() == 0) begin
                            chk(0, "R3", "unexpected memory write", {16'h0, mem_addr}, 0);
                        end else begin
                            item_t it;
                            it = expq.pop_front();
                            chk(mem_addr == it.a, "R3", "write address", {16'h0, mem_addr}, {16'h0, it.a});
                            chk(mem_wdata == it.d, "R3", "write data", mem_wdata, it.d);
                            chk(mem_we == 1'b1, "R3", "write enable", 32'(mem_we), 1);
                        end
                        if (coll_arm && expq.size() == 0) begin
                            coll_we = 1'b1;
                            coll_arm = 0;
                            coll_fired = 1;
                        end
                    end else begin
                        chk(tb_dir, "R4", "read only in memory-to-device", 32'(mem_we), 1);
                        mem_rdata = mem[mem_addr[7:0]];
                    end
                end else begin
                    mem_ready = 1'b0;
                    mcnt++;
                end
            end else begin
                mem_ready = 1'b0;
                mcnt = 0;
            end
            dev_rx_valid = (srcq.size() > 0) && (cyc % 3 != 0);
            if (srcq.size() > 0) dev_rx_data = srcq[0];
            if (dev_rx_valid && dev_rx_ready) begin
                void'(srcq.pop_front());
                pend++;
            end
            dev_tx_ready = sink_on && (cyc % 4 != 1);
            if (dev_tx_valid && dev_tx_ready) begin
                if (expq.size() == 0) begin
                    chk(0, "R4", "unexpected device word", dev_tx_data, 0);
                end else begin
                    item_t it;
                    it = expq.pop_front();
                    chk(dev_tx_data == it.d, "R4", "device word", dev_tx_data, it.d);
                end
            end
            req_prev = bus_req;
            tx_rdy_prev = dev_tx_ready;
            hs_prev = hs_now;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        host_addr = a;
        #1;
        v = cfg_rdata;
    endtask

    task automatic wait_irq(input string req);
        for (int i = 0; i < 3000 && !irq; i++) @(negedge clk);
        chk(irq, req, "interrupt at block end", 32'(irq), 1);
    endtask

    initial begin
        logic [31:0] v;
        bit saw_req;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(!irq && !bus_req && !mem_valid, "R1", "outputs after reset",
            {29'h0, irq, bus_req, mem_valid}, 0);
        chk(!dev_rx_ready && !dev_tx_valid, "R1", "device handshake after reset",
            {30'h0, dev_rx_ready, dev_tx_valid}, 0);
        for (int k = 0; k < 4; k++) begin
            rd(2'(k), v);
            chk(v == 0, "R1", "register after reset", v, 0);
        end

        // R2 / R11 programming
        wr(2'd1, 32'h5);
        wr(2'd2, 32'h10);
        wr(2'd3, 32'h5);
        rd(2'd1, v); chk(v == 32'h5, "R2", "device id readback", v, 5);
        rd(2'd2, v); chk(v == 32'h10, "R2", "address readback", v, 32'h10);
        rd(2'd3, v); chk(v == 32'h5, "R2", "count readback", v, 5);
        chk(dev_id == 4'h5, "R11", "device id output", 32'(dev_id), 5);

        // device to memory, 5 words
        tb_dir = 0; gnt_lat = 2; mem_lat = 2;
        plan_in(5, 16'h10, 32'hA5A5_0000);
        wr(2'd0, 32'h1);
        rd(2'd0, v); chk(v[0] == 1'b1, "R2", "busy bit during block", v, 1);
        // R8: ignored while busy
        wr(2'd2, 32'h80);
        wr(2'd1, 32'h9);
        wr(2'd0, 32'h3);
        chk(dev_id == 4'h5, "R8", "identifier locked while busy", 32'(dev_id), 5);
        wait_irq("R7");
        @(negedge clk);
        chk(expq.size() == 0, "R3", "all words written", expq.size(), 0);
        rd(2'd2, v); chk(v == 32'h15, "R3", "final address", v, 32'h15);
        rd(2'd3, v); chk(v == 32'h0, "R3", "final count", v, 0);
        rd(2'd0, v); chk(v == 32'h2, "R8", "status idle, irq, direction kept", v, 2);
        repeat (6) @(negedge clk);
        chk(irq, "R7", "interrupt held", 32'(irq), 1);
        wr(2'd0, 32'h4);
        chk(!irq, "R7", "interrupt cleared", 32'(irq), 0);

        // memory to device, 4 words
        tb_dir = 1; sink_on = 1; gnt_lat = 0; mem_lat = 1;
        plan_out(4, 16'h40, 32'h7700_0010);
        wr(2'd2, 32'h40);
        wr(2'd3, 32'h4);
        wr(2'd0, 32'h3);
        wait_irq("R7");
        @(negedge clk);
        chk(expq.size() == 0, "R4", "all words delivered", expq.size(), 0);
        rd(2'd2, v); chk(v == 32'h44, "R4", "final address", v, 32'h44);
        rd(2'd0, v); chk(v == 32'h6, "R2", "status with direction", v, 6);
        wr(2'd0, 32'h4);
        sink_on = 0; tb_dir = 0;

        // R9: zero count
        wr(2'd3, 32'h0);
        wr(2'd0, 32'h1);
        saw_req = 0;
        for (int i = 0; i < 10; i++) begin
            if (bus_req) saw_req = 1;
            @(negedge clk);
        end
        chk(!saw_req, "R9", "no request on empty block", 32'(saw_req), 0);
        chk(irq, "R9", "interrupt on empty block", 32'(irq), 1);
        wr(2'd0, 32'h4);

        // R10: clear coinciding with completion
        gnt_lat = 1; mem_lat = 1;
        plan_in(1, 16'h30, 32'h0BAD_CAFE);
        wr(2'd2, 32'h30);
        wr(2'd3, 32'h1);
        coll_arm = 1;
        wr(2'd0, 32'h1);
        for (int i = 0; i < 500 && !coll_fired; i++) @(negedge clk);
        chk(coll_fired, "R10", "collision provoked", 32'(coll_fired), 1);
        repeat (3) @(negedge clk);
        chk(irq, "R10", "set wins over clear", 32'(irq), 1);
        wr(2'd0, 32'h4);
        chk(!irq, "R7", "later clear works", 32'(irq), 0);

        // longer device to memory run, immediate grant
        gnt_lat = 0; mem_lat = 0;
        plan_in(8, 16'h60, 32'h1234_5678);
        wr(2'd2, 32'h60);
        wr(2'd3, 32'h8);
        wr(2'd0, 32'h1);
        wait_irq("R7");
        @(negedge clk);
        chk(expq.size() == 0, "R3", "long block written", expq.size(), 0);
        rd(2'd2, v); chk(v == 32'h68, "R3", "long block final address", v, 32'h68);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule